// File: doc/BRIEF.md
# Loopback UART Register Model

This block presents the eight byte-wide registers of a 16550-compatible serial port to a host, but has no serial line behind them. Every byte written to the transmit register is stored in a 16-entry circular ring, and reading the receive register drains that ring in arrival order. Line status, modem status and interrupt identification are all derived from ring occupancy, a sticky overrun flag and the stored control registers.

The host port is a 3-bit offset with separate read and write strobes, one access per cycle. Read data is combinational from the current state and the offset, and the side effects of the access (pop, push, register update) take place on the clock edge that ends it. Interrupt causes are reported as a one-cycle pulse on `irq_o` in the cycle after the access that raised them, so the consumer can count or forward them as edge events.

Top module: `uart_loopback_regs`

## Requirements
- R1: After reset the ring is empty, LCR, IER, MCR, SCR and the divisor are zero, and FIFO mode is on (depth 16); IIR reads 0xC1, LSR reads 0x60 and MSR reads 0xB3.
- R2: A write to offset 3 stores the whole byte and reads back unchanged; bit 7 of that byte selects divisor mode, and writing it as 1 zeroes the 16-bit divisor.
- R3: In divisor mode offset 0 reads and writes the divisor low byte and offset 1 the high byte, leaving the ring and IER untouched.
- R4: Outside divisor mode, writes to offset 0 enter the ring and reads of offset 0 return the bytes in write order, with head and tail wrapping modulo 16.
- R5: The ring holds 16 bytes when FCR bit 0 was last written as 1 and 1 byte when it was written as 0; a write to a full ring is dropped and sets the overrun flag, and a stored write clears it.
- R6: An FCR write (offset 2) with bit 1 or bit 2 set empties the ring.
- R7: Offset 1 outside divisor mode keeps only bits 3:0 of the written byte and reads back zeros in bits 7:4.
- R8: IIR (read offset 2) reports the highest pending cause: 0xC6 overrun with IER bit 2, then 0xC4 ring count equal to 1 with IER bit 0, then 0xC2 empty ring with IER bit 1, then 0xC0 MCR bit 0 or 1 with IER bit 3, else 0xC1.
- R9: LSR (offset 5) has bit 0 set when the ring holds data, bit 1 when overrun is set, and bits 5 and 6 when the ring is empty; all other bits are zero.
- R10: MSR (offset 6) always has bits 1, 5 and 7 set; bits 0 and 4 are set except when MCR bit 5 is set and the ring is full.
- R11: SCR (offset 7) and MCR (offset 4) read back the written byte; writes to offsets 5 and 6 change nothing.
- R12: `irq_o` pulses for one cycle after: a stored byte making the count 1 with IER bit 0; a dropped byte with IER bit 2; an IER write with bit 1 set while empty; an MCR write with bit 0, 1 or 3 set while IER bit 3 is set; a data read that leaves the ring empty with IER bit 1.
- R13: A data read of an empty ring returns 0x00 and leaves the ring and overrun flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data for the current offset |
| irq_o | output | 1 | One-cycle interrupt event |

## Verification
The assertions take for granted that the host never raises the read and write strobes in the same cycle, since the pop and push side effects are defined for one access at a time; this is itself checked as an input assertion. The stimulus issues exactly one access per transaction from a single task, so the strobes are exclusive by construction, and random FCR values frequently clear the ring while directed sequences fill it to the overflow point in both depth modes.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OFS_W  = 3;
  localparam int unsigned DIV_W  = 2 * DATA_W;
  localparam int unsigned TRIG   = 1;

  typedef enum logic [OFS_W-1:0] {
    OFS_DATA  = 3'd0,
    OFS_IER   = 3'd1,
    OFS_FCTL  = 3'd2,
    OFS_LCR   = 3'd3,
    OFS_MCR   = 3'd4,
    OFS_LSR   = 3'd5,
    OFS_MSR   = 3'd6,
    OFS_SCR   = 3'd7
  } reg_ofs_e;

  localparam int unsigned IE_RX    = 0;
  localparam int unsigned IE_TX    = 1;
  localparam int unsigned IE_LINE  = 2;
  localparam int unsigned IE_MODEM = 3;

  localparam int unsigned FC_EN    = 0;
  localparam int unsigned FC_CLR_A = 1;
  localparam int unsigned FC_CLR_B = 2;

  localparam int unsigned LC_DIV   = 7;

  localparam int unsigned MC_DTR   = 0;
  localparam int unsigned MC_RTS   = 1;
  localparam int unsigned MC_OUT2  = 3;
  localparam int unsigned MC_AFE   = 5;

  localparam logic [7:0] ID_LINE  = 8'hC6;
  localparam logic [7:0] ID_RX    = 8'hC4;
  localparam logic [7:0] ID_TX    = 8'hC2;
  localparam logic [7:0] ID_MODEM = 8'hC0;
  localparam logic [7:0] ID_NONE  = 8'hC1;
endpackage

// File: rtl/lb_ring.sv
module lb_ring #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem_q[head_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) head_q <= ptr_inc(head_q);
      if (pop_i)  tail_q <= ptr_inc(tail_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign rdata_o = mem_q[tail_q];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);

  a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r4_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/lb_regs.sv
module lb_regs
  import uart_lb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              full_i,
  output logic [DATA_W-1:0] lcr_o,
  output logic [3:0]        ier_o,
  output logic [DATA_W-1:0] mcr_o,
  output logic [DATA_W-1:0] scr_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              deep_o,
  output logic              ovr_o,
  output logic              push_o,
  output logic              clr_o
);
  logic [DATA_W-1:0] lcr_q, mcr_q, scr_q;
  logic [3:0]        ier_q;
  logic [DIV_W-1:0]  div_q;
  logic              deep_q, ovr_q;
  logic              dlab, wr_data, drop;

  assign dlab    = lcr_q[LC_DIV];
  assign wr_data = wr_i && (addr_i == OFS_DATA) && !dlab;
  assign push_o  = wr_data && !full_i;
  assign drop    = wr_data && full_i;
  assign clr_o   = wr_i && (addr_i == OFS_FCTL) &&
                   (wdata_i[FC_CLR_A] || wdata_i[FC_CLR_B]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q  <= '0;
      ier_q  <= '0;
      mcr_q  <= '0;
      scr_q  <= '0;
      div_q  <= '0;
      deep_q <= 1'b1;
      ovr_q  <= 1'b0;
    end else begin
      if (push_o) ovr_q <= 1'b0;
      else if (drop) ovr_q <= 1'b1;
      if (wr_i) begin
        unique case (addr_i)
          OFS_DATA: if (dlab) div_q[DATA_W-1:0] <= wdata_i;
          OFS_IER: begin
            if (dlab) div_q[DIV_W-1:DATA_W] <= wdata_i;
            else      ier_q <= wdata_i[3:0];
          end
          OFS_FCTL: deep_q <= wdata_i[FC_EN];
          OFS_LCR: begin
            lcr_q <= wdata_i;
            if (wdata_i[LC_DIV]) div_q <= '0;
          end
          OFS_MCR: mcr_q <= wdata_i;
          OFS_SCR: scr_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign lcr_o  = lcr_q;
  assign ier_o  = ier_q;
  assign mcr_o  = mcr_q;
  assign scr_o  = scr_q;
  assign div_o  = div_q;
  assign deep_o = deep_q;
  assign ovr_o  = ovr_q;

  a_r11_status_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == OFS_LSR || addr_i == OFS_MSR)) |=>
      ($stable(lcr_q) && $stable(ier_q) && $stable(mcr_q) && $stable(scr_q)));
endmodule

// File: rtl/lb_evt.sv
module lb_evt
  import uart_lb_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              dlab_i,
  input  logic [3:0]        ier_i,
  input  logic [DATA_W-1:0] mcr_i,
  input  logic [CW-1:0]     count_i,
  input  logic              full_i,
  input  logic              ovr_i,
  output logic [DATA_W-1:0] iir_o,
  output logic [DATA_W-1:0] lsr_o,
  output logic [DATA_W-1:0] msr_o,
  output logic              irq_o
);
  logic empty, rx_hit, modem_act, evt, irq_q;

  assign empty     = (count_i == '0);
  assign rx_hit    = (count_i == CW'(TRIG));
  assign modem_act = mcr_i[MC_RTS] || mcr_i[MC_DTR];

  always_comb begin
    if (ovr_i && ier_i[IE_LINE])              iir_o = ID_LINE;
    else if (rx_hit && ier_i[IE_RX])          iir_o = ID_RX;
    else if (empty && ier_i[IE_TX])           iir_o = ID_TX;
    else if (modem_act && ier_i[IE_MODEM])    iir_o = ID_MODEM;
    else                                      iir_o = ID_NONE;
  end

  assign lsr_o = {1'b0, empty, empty, 3'b000, ovr_i, !empty};
  // CTS and delta-CTS withheld only under auto flow with a full ring
  assign msr_o = {1'b1, 1'b0, 1'b1, !(mcr_i[MC_AFE] && full_i),
                  2'b00, 1'b1, !(mcr_i[MC_AFE] && full_i)};

  always_comb begin
    evt = 1'b0;
    if (wr_i) begin
      unique case (addr_i)
        OFS_DATA: if (!dlab_i)
          evt = full_i ? ier_i[IE_LINE]
                       : (ier_i[IE_RX] && count_i == CW'(TRIG - 1));
        OFS_IER:  if (!dlab_i) evt = wdata_i[IE_TX] && empty;
        OFS_MCR:  evt = ier_i[IE_MODEM] &&
                        (wdata_i[MC_OUT2] || wdata_i[MC_RTS] || wdata_i[MC_DTR]);
        default:  evt = 1'b0;
      endcase
    end else if (rd_i && addr_i == OFS_DATA && !dlab_i) begin
      evt = ier_i[IE_TX] && (count_i <= CW'(1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= evt;
  end
  assign irq_o = irq_q;

  a_r12_irq_follows_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(wr_i || rd_i));
  a_r10_cts_withheld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcr_i[MC_AFE] && full_i) |-> (msr_o[4] == 1'b0 && msr_o[0] == 1'b0));
endmodule

// File: rtl/uart_loopback_regs.sv
module uart_loopback_regs
  import uart_lb_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wr_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] lcr, mcr, scr, ring_dout, iir, lsr, msr;
  logic [3:0]        ier;
  logic [DIV_W-1:0]  div;
  logic [CW-1:0]     count;
  logic              deep, ovr, push, clr, pop, empty, full, dlab;

  assign dlab = lcr[LC_DIV];
  assign full = count >= (deep ? CW'(DEPTH) : CW'(1));
  assign pop  = rd_i && (addr_i == OFS_DATA) && !dlab && !empty;

  lb_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .full_i  (full),
    .lcr_o   (lcr),
    .ier_o   (ier),
    .mcr_o   (mcr),
    .scr_o   (scr),
    .div_o   (div),
    .deep_o  (deep),
    .ovr_o   (ovr),
    .push_o  (push),
    .clr_o   (clr)
  );

  lb_ring #(.DEPTH(DEPTH), .DW(DATA_W)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .push_i  (push),
    .wdata_i (wdata_i),
    .pop_i   (pop),
    .rdata_o (ring_dout),
    .count_o (count),
    .empty_o (empty)
  );

  lb_evt #(.CW(CW)) u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .dlab_i  (dlab),
    .ier_i   (ier),
    .mcr_i   (mcr),
    .count_i (count),
    .full_i  (full),
    .ovr_i   (ovr),
    .iir_o   (iir),
    .lsr_o   (lsr),
    .msr_o   (msr),
    .irq_o   (irq_o)
  );

  always_comb begin
    unique case (addr_i)
      OFS_DATA: rdata_o = dlab ? div[DATA_W-1:0] : (empty ? '0 : ring_dout);
      OFS_IER:  rdata_o = dlab ? div[DIV_W-1:DATA_W] : {4'b0000, ier};
      OFS_FCTL: rdata_o = iir;
      OFS_LCR:  rdata_o = lcr;
      OFS_MCR:  rdata_o = mcr;
      OFS_LSR:  rdata_o = lsr;
      OFS_MSR:  rdata_o = msr;
      default:  rdata_o = scr;
    endcase
  end

  a_r12_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && rd_i));
  a_r5_drop_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_DATA && !dlab && full) |=> ($stable(count) && ovr));
  a_r6_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_FCTL && (wdata_i[FC_CLR_A] || wdata_i[FC_CLR_B]))
      |=> (count == '0));
  a_r2_div_zeroed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_LCR && wdata_i[LC_DIV]) |=> (div == '0));
  a_r13_empty_read_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFS_DATA && !dlab && empty) |=> (empty && $stable(ovr)));
endmodule

// File: tb/uart_loopback_regs_test.sv
`timescale 1ns/1ps
module uart_loopback_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_loopback_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .irq_o(irq)
  );

  // reference model
  logic [7:0]  m_buf [16];
  int          m_head = 0, m_tail = 0, m_cnt = 0;
  bit          m_deep = 1, m_ovr = 0;
  logic [7:0]  m_lcr = 0, m_mcr = 0, m_scr = 0;
  logic [3:0]  m_ier = 0;
  logic [15:0] m_div = 0;

  function automatic int maxd();
    return m_deep ? 16 : 1;
  endfunction

  function automatic logic [7:0] peek(input logic [2:0] a);
    bit e = (m_cnt == 0);
    case (a)
      3'd0: return m_lcr[7] ? m_div[7:0] : (e ? 8'h00 : m_buf[m_tail]);
      3'd1: return m_lcr[7] ? m_div[15:8] : {4'h0, m_ier};
      3'd2: begin
        if (m_ovr && m_ier[2])                   return 8'hC6;
        if (m_ier[0] && m_cnt == 1)              return 8'hC4;
        if (m_ier[1] && e)                       return 8'hC2;
        if (m_ier[3] && (m_mcr[1] || m_mcr[0]))  return 8'hC0;
        return 8'hC1;
      end
      3'd3: return m_lcr;
      3'd4: return m_mcr;
      3'd5: return {1'b0, e, e, 3'b000, m_ovr, !e};
      3'd6: return (m_mcr[5] && m_cnt >= maxd()) ? 8'hA2 : 8'hB3;
      default: return m_scr;
    endcase
  endfunction

  function automatic bit model_write(input logic [2:0] a, input logic [7:0] d);
    bit ev = 0;
    case (a)
      3'd0: if (m_lcr[7]) m_div[7:0] = d;
            else if (m_cnt < maxd()) begin
              m_buf[m_head] = d; m_head = (m_head + 1) % 16; m_cnt++;
              m_ovr = 0; ev = m_ier[0] && (m_cnt == 1);
            end else begin
              m_ovr = 1; ev = m_ier[2];
            end
      3'd1: if (m_lcr[7]) m_div[15:8] = d;
            else begin m_ier = d[3:0]; ev = d[1] && (m_cnt == 0); end
      3'd2: begin
        m_deep = d[0];
        if (d[1] || d[2]) begin m_cnt = 0; m_head = 0; m_tail = 0; end
      end
      3'd3: begin m_lcr = d; if (d[7]) m_div = 0; end
      3'd4: begin m_mcr = d; ev = m_ier[3] && (d[3] || d[1] || d[0]); end
      3'd7: m_scr = d;
      default: ;
    endcase
    return ev;
  endfunction

  function automatic bit model_read(input logic [2:0] a);
    bit ev = 0;
    if (a == 3'd0 && !m_lcr[7]) begin
      if (m_cnt > 0) begin m_tail = (m_tail + 1) % 16; m_cnt--; end
      ev = m_ier[1] && (m_cnt == 0);
    end
    return ev;
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return m_lcr[7] ? "R3" : "R4";
      3'd1: return m_lcr[7] ? "R3" : "R7";
      3'd2: return "R8";
      3'd3: return "R2";
      3'd4: return "R11";
      3'd5: return "R9";
      3'd6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic access(input bit is_wr, input logic [2:0] a, input logic [7:0] d,
                        input string tag);
    logic [7:0] exp_rd;
    bit exp_irq;
    exp_rd  = peek(a);
    exp_irq = is_wr ? model_write(a, d) : model_read(a);
    @(negedge clk);
    addr = a; wdata = d; wr = is_wr; rd = !is_wr;
    #1;
    if (!is_wr) check(tag, rdata, exp_rd);
    @(negedge clk);
    wr = 0; rd = 0;
    check("R12", {7'd0, irq}, {7'd0, exp_irq});
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    access(1'b1, a, d, "R12");
  endtask

  task automatic rd_reg(input logic [2:0] a, input string tag);
    access(1'b0, a, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(3'd5, "R1"); rd_reg(3'd2, "R1"); rd_reg(3'd6, "R1");
    rd_reg(3'd3, "R1"); rd_reg(3'd1, "R1"); rd_reg(3'd7, "R1");
    rd_reg(3'd0, "R13");

    // R11 scratch and ignored status writes
    wr_reg(3'd7, 8'h5A); rd_reg(3'd7, "R11");
    wr_reg(3'd5, 8'hFF); wr_reg(3'd6, 8'hFF);
    rd_reg(3'd5, "R11"); rd_reg(3'd6, "R11");
    wr_reg(3'd4, 8'hC4); rd_reg(3'd4, "R11"); wr_reg(3'd4, 8'h00);

    // R2 / R3 divisor mode
    wr_reg(3'd3, 8'h83); wr_reg(3'd0, 8'h34); wr_reg(3'd1, 8'h12);
    rd_reg(3'd0, "R3"); rd_reg(3'd1, "R3"); rd_reg(3'd3, "R2");
    wr_reg(3'd3, 8'h03); rd_reg(3'd1, "R3"); rd_reg(3'd5, "R3");
    wr_reg(3'd3, 8'h80); rd_reg(3'd0, "R2"); rd_reg(3'd1, "R2");
    wr_reg(3'd3, 8'h1B); rd_reg(3'd3, "R2");

    // R4 / R5 fill, overflow, drain, wrap
    for (int i = 0; i < 16; i++) wr_reg(3'd0, 8'h10 + 8'(i));
    wr_reg(3'd0, 8'hEE);
    rd_reg(3'd5, "R5");
    wr_reg(3'd4, 8'h20); rd_reg(3'd6, "R10"); wr_reg(3'd4, 8'h00);
    rd_reg(3'd6, "R10");
    for (int i = 0; i < 16; i++) rd_reg(3'd0, "R4");
    rd_reg(3'd5, "R9");
    for (int i = 0; i < 7; i++) wr_reg(3'd0, 8'hA0 + 8'(i));
    for (int i = 0; i < 7; i++) rd_reg(3'd0, "R4");
    rd_reg(3'd0, "R13"); rd_reg(3'd5, "R13");

    // R5 single-entry mode
    wr_reg(3'd2, 8'h00);
    wr_reg(3'd0, 8'hAA); wr_reg(3'd0, 8'hBB);
    rd_reg(3'd5, "R5"); rd_reg(3'd0, "R5"); rd_reg(3'd0, "R13");
    wr_reg(3'd2, 8'h01);

    // R6 clear
    for (int i = 0; i < 3; i++) wr_reg(3'd0, 8'h77);
    wr_reg(3'd2, 8'h03); rd_reg(3'd5, "R6");
    wr_reg(3'd0, 8'h55); wr_reg(3'd2, 8'h05); rd_reg(3'd5, "R6");

    // R7 / R8 / R12 interrupt sources and priority
    wr_reg(3'd1, 8'hFF); rd_reg(3'd1, "R7"); rd_reg(3'd2, "R8");
    wr_reg(3'd0, 8'h01); rd_reg(3'd2, "R8");
    wr_reg(3'd0, 8'h02); rd_reg(3'd2, "R8");
    wr_reg(3'd4, 8'h03); rd_reg(3'd2, "R8");
    for (int i = 0; i < 15; i++) wr_reg(3'd0, 8'h30);
    rd_reg(3'd2, "R8");
    wr_reg(3'd4, 8'h08);
    for (int i = 0; i < 16; i++) rd_reg(3'd0, "R4");
    rd_reg(3'd2, "R8");
    wr_reg(3'd1, 8'h00); rd_reg(3'd2, "R8");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int sel = int'($urandom_range(0, 99));
      logic [7:0] d = 8'($urandom);
      logic [2:0] a = 3'($urandom);
      if (sel < 35)      wr_reg(3'd0, d);
      else if (sel < 65) rd_reg(3'd0, tag_of(3'd0));
      else if (sel < 80) rd_reg(a, tag_of(a));
      else begin
        if (a == 3'd3) d[7] = ($urandom_range(0, 3) == 0);
        wr_reg(a, d);
      end
    end
    wr_reg(3'd3, 8'h03);
    rd_reg(3'd5, "R9");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule